// File: doc/BRIEF.md
# Condition Code Predicate Unit

This unit holds the four arithmetic flags of a processor core (negative, zero, carry, overflow) and tells the issue logic whether an instruction's 4-bit condition field allows it to execute. The `pass` output is a combinational function of the condition field and the flag register. Because the flags are registered, a flag update becomes visible to `pass` one cycle after it is written.

There are two ways to write the flags. The ALU can supply a fresh set of four flags. Software can also write a whole status word, and the unit takes the four flags from its top nibble. The same word layout comes back on the read port, with the flags in the top four bits and every lower bit reading as zero. If both kinds of write arrive in the same cycle, the status-word write wins.

Top module: `cond_eval`

## Requirements
- R1: After reset all four flags are 0, so `psr_rdata` reads 0.
- R2: A status-word write (`psr_we`=1) loads N from bit 31, Z from bit 30, C from bit 29 and V from bit 28 of `psr_wdata` at the next clock edge. The lower bits are ignored. `psr_rdata` returns {N,Z,C,V} in bits 31..28 with bits 27..0 at zero.
- R3: An ALU update (`alu_we`=1, `psr_we`=0) loads `alu_n`, `alu_z`, `alu_c` and `alu_v` into the flags at the next clock edge.
- R4: When `psr_we` and `alu_we` are both 1 in the same cycle, the flags take the status-word values and the ALU values are ignored.
- R5: Code 0000 passes when Z=1. Code 0001 passes when Z=0.
- R6: Code 0010 passes when C=1 and 0011 when C=0. Code 0100 passes when N=1 and 0101 when N=0. Code 0110 passes when V=1 and 0111 when V=0.
- R7: Code 1000 (unsigned higher) passes when C=1 and Z=0. Code 1001 (lower or same) passes when C=0 or Z=1.
- R8: Code 1010 (signed greater or equal) passes when N=V. Code 1011 (signed less) passes when N differs from V.
- R9: Code 1100 (signed greater) passes when Z=0 and N=V. Code 1101 (signed less or equal) passes when Z=1 or N differs from V.
- R10: Code 1110 always passes. Code 1111 never passes.
- R11: When neither write enable is set, the flags and `psr_rdata` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond | input | 4 | Condition field to evaluate |
| psr_we | input | 1 | Status-word write enable |
| psr_wdata | input | 32 | Status word to load |
| alu_we | input | 1 | ALU flag update enable |
| alu_n | input | 1 | New negative flag from the ALU |
| alu_z | input | 1 | New zero flag from the ALU |
| alu_c | input | 1 | New carry flag from the ALU |
| alu_v | input | 1 | New overflow flag from the ALU |
| psr_rdata | output | 32 | Status word readback |
| pass | output | 1 | Condition passes for the current flags |

## Verification
The status-word write and the ALU flag update can fall in the same cycle. The bench raises both enables together, with each side carrying a flag pattern chosen to be the other's complement. After the clock edge it judges the result by reading the status word and by evaluating conditions that separate the two patterns. Every condition code is also checked against all sixteen flag combinations, which are loaded by both write paths.

// File: rtl/cond_eval.sv
module cond_eval #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cond,
  input  logic              psr_we,
  input  logic [WORD_W-1:0] psr_wdata,
  input  logic              alu_we,
  input  logic              alu_n,
  input  logic              alu_z,
  input  logic              alu_c,
  input  logic              alu_v,
  output logic [WORD_W-1:0] psr_rdata,
  output logic              pass
);
  localparam int N_POS = WORD_W - 1;
  localparam int Z_POS = WORD_W - 2;
  localparam int C_POS = WORD_W - 3;
  localparam int V_POS = WORD_W - 4;

  logic fn, fz, fc, fv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fn <= 1'b0; fz <= 1'b0; fc <= 1'b0; fv <= 1'b0;
    end else if (psr_we) begin
      fn <= psr_wdata[N_POS];
      fz <= psr_wdata[Z_POS];
      fc <= psr_wdata[C_POS];
      fv <= psr_wdata[V_POS];
    end else if (alu_we) begin
      fn <= alu_n; fz <= alu_z; fc <= alu_c; fv <= alu_v;
    end
  end

  assign psr_rdata = {fn, fz, fc, fv, {(WORD_W-4){1'b0}}};

  wire sgn_ge = (fn == fv);

  always_comb begin
    unique case (cond)
      4'h0: pass = fz;
      4'h1: pass = !fz;
      4'h2: pass = fc;
      4'h3: pass = !fc;
      4'h4: pass = fn;
      4'h5: pass = !fn;
      4'h6: pass = fv;
      4'h7: pass = !fv;
      4'h8: pass = fc && !fz;
      4'h9: pass = !fc || fz;
      4'hA: pass = sgn_ge;
      4'hB: pass = !sgn_ge;
      4'hC: pass = !fz && sgn_ge;
      4'hD: pass = fz || !sgn_ge;
      4'hE: pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

  a_r4_psr_priority: assert property (@(posedge clk) disable iff (!rst_n)
    psr_we |=> psr_rdata[N_POS:V_POS] == $past(psr_wdata[N_POS:V_POS]));

  a_r3_alu_load: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && !psr_we) |=> psr_rdata[N_POS:V_POS] == $past({alu_n, alu_z, alu_c, alu_v}));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!psr_we && !alu_we) |=> $stable(psr_rdata));

  a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    psr_rdata[V_POS-1:0] == '0);

  a_r10_always: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'hE) |-> pass);

  a_r10_never: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'hF) |-> !pass);

  a_r7_hi_ls_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'h8 && psr_rdata[Z_POS]) |-> !pass);
endmodule

// File: tb/test_cond_eval.sv
module test_cond_eval;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  cond = 0;
  logic        psr_we = 0;
  logic [31:0] psr_wdata = 0;
  logic        alu_we = 0;
  logic        alu_n = 0, alu_z = 0, alu_c = 0, alu_v = 0;
  logic [31:0] psr_rdata;
  logic        pass;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cond_eval i_cond_eval (
    .clk(clk), .rst_n(rst_n), .cond(cond),
    .psr_we(psr_we), .psr_wdata(psr_wdata),
    .alu_we(alu_we), .alu_n(alu_n), .alu_z(alu_z), .alu_c(alu_c), .alu_v(alu_v),
    .psr_rdata(psr_rdata), .pass(pass)
  );

  function automatic logic model(input logic [3:0] c, input logic [3:0] nzcv);
    logic n, z, cy, v;
    {n, z, cy, v} = nzcv;
    case (c)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return cy;
      4'h3: return !cy;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return cy & !z;
      4'h9: return !cy | z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z & (n == v);
      4'hD: return z | (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c <= 4'h1) return "R5";
    if (c <= 4'h7) return "R6";
    if (c <= 4'h9) return "R7";
    if (c <= 4'hB) return "R8";
    if (c <= 4'hD) return "R9";
    return "R10";
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sweep_conds(input logic [3:0] nzcv);
    for (int c = 0; c < 16; c++) begin
      cond = 4'(c);
      #1;
      total++;
      if (pass !== model(4'(c), nzcv)) begin
        bad++;
        $display("FAIL %s: cond=%h flags=%b actual=%b expected=%b",
                 req_of(4'(c)), c, nzcv, pass, model(4'(c), nzcv));
      end
    end
  endtask

  task automatic t_reset;
    check32("R1", psr_rdata, 32'h0);
    sweep_conds(4'b0000);
  endtask

  task automatic t_psr_load;
    for (int f = 0; f < 16; f++) begin
      @(negedge clk);
      psr_we = 1;
      psr_wdata = {4'(f), 28'h5A5A5A5};
      @(negedge clk);
      psr_we = 0;
      check32("R2", psr_rdata, {4'(f), 28'h0});
      sweep_conds(4'(f));
    end
  endtask

  task automatic t_alu_load;
    for (int f = 15; f >= 0; f--) begin
      @(negedge clk);
      alu_we = 1;
      {alu_n, alu_z, alu_c, alu_v} = 4'(f);
      @(negedge clk);
      alu_we = 0;
      check32("R3", psr_rdata, {4'(f), 28'h0});
      sweep_conds(4'(f));
    end
  endtask

  task automatic t_priority;
    @(negedge clk);
    psr_we = 1;
    psr_wdata = 32'hA000_0000;
    alu_we = 1;
    {alu_n, alu_z, alu_c, alu_v} = 4'b0101;
    @(negedge clk);
    psr_we = 0;
    alu_we = 0;
    check32("R4", psr_rdata, 32'hA000_0000);
    sweep_conds(4'b1010);
  endtask

  task automatic t_hold;
    @(negedge clk);
    psr_we = 1;
    psr_wdata = 32'h6000_0000;
    @(negedge clk);
    psr_we = 0;
    psr_wdata = 32'hF000_0000;
    {alu_n, alu_z, alu_c, alu_v} = 4'b1001;
    repeat (3) @(negedge clk);
    check32("R11", psr_rdata, 32'h6000_0000);
    sweep_conds(4'b0110);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_psr_load();
    t_alu_load();
    t_priority();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule